// File: doc/BRIEF.md
# Byte-Mapped Audio Frame Splitter

This block receives one multichannel audio stream, one byte per beat, and breaks every input frame into four output frames. Each of the 64 output byte slots is filled from an input byte chosen by a programmable map. Each slot also has its own enable bit. A disabled slot adds nothing to its output, so the enabled bytes of each output are packed together toward byte 0.

Software programs the block through a small register port. That port holds a control word (output enables, channel count and sample width), two 32-bit slot-enable words, a pointer/mode register, and a data window into the map RAM. The map RAM holds 16 words of four entries each. Each output is a single-beat valid/ready transfer. The beat carries up to 16 packed bytes and a count of the bytes that are valid.

A frame is released to the outputs only after all of its bytes have arrived. While any output still holds an undelivered frame, the input is stalled.

Top module: `adx_byte_demux`

## Requirements
- R1: After reset all registers read as zero, `in_ready` is 1 and `out_valid` is 0. The register addresses are: 0 control, 1 slot enables 0..31, 2 slot enables 32..63, 3 RAM pointer/mode, 4 RAM data. Other addresses read 0 and ignore writes. Control layout: [3:0] output enables, [11:8] channels minus one, [13:12] width code. Bits outside this layout read as 0.
- R2: Writing register 3 with bit 12 set loads the pointer from bits [3:0]. Bit 13 selects sequential mode and bit 14 selects write mode. In sequential write mode each write to register 4 stores the word at the pointer and then advances the pointer, wrapping after word 15. RAM word w holds entry 4w+b in bits [8b+7:8b]. Register 3 reads back {bit14 write mode, bit13 sequential, [3:0] pointer}.
- R3: A write to register 4 while write mode is clear is ignored. A read of register 4 returns the word at the pointer. In sequential mode with write mode clear, the read advances the pointer. Without sequential mode the pointer holds.
- R4: A read of register 4 returns 0 in every byte whose entry is disabled.
- R5: Entry n is enabled by bit n%32 of enable word n/32 (word 0 at register 1, word 1 at register 2).
- R6: The frame length in bytes is (channels) × (1, 2 or 4). Width code 0 selects 8-bit samples, 1 selects 16-bit, and 2 or 3 select 32-bit.
- R7: Output k (0..3) uses entries 16k..16k+15 in slot order. Bits [5:0] of an entry give the input byte index. Bits [7:6] are ignored.
- R8: An index at or beyond the frame length yields a zero byte.
- R9: Enabled slots are packed in slot order from byte 0 of `out_data` for that output. The count equals the number of enabled slots, and bytes above the count are zero.
- R10: An output becomes valid only after the last byte of a frame is accepted. The output enables are sampled at that moment. `in_ready` is low while any output is pending.
- R11: A pending output keeps `out_valid` high until its `out_ready`. The outputs complete independently. The next frame is accepted once all pending outputs have completed.
- R12: With all output enables clear, a completed frame is discarded. No output becomes valid and `in_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (affects only the RAM pointer) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| out_valid | output | 4 | One valid per output |
| out_ready | input | 4 | One ready per output |
| out_data | output | 512 | Output k uses bits [128k+127:128k], packed bytes |
| out_count | output | 20 | Output k uses bits [5k+4:5k], number of valid bytes |

## Verification
A wrong map pointer shows up as shifted or repeated words on the very next data-register read. A stale slot enable shows up as a wrong packing or a wrong byte count on the first output beat that follows. A capture counter that has slipped makes the outputs go valid one or more bytes early or late, so the per-clock comparison of `in_ready` and `out_valid` catches it within that frame. A lost pending bit either drops an output beat or leaves the input stalled, and the reference model flags the mismatch on the same clock.

// File: rtl/adx_pkg.sv
package adx_pkg;
    localparam int ADX_OUTS        = 4;
    localparam int ADX_SLOTS       = 16;
    localparam int ADX_ENTRIES     = ADX_OUTS * ADX_SLOTS;
    localparam int ADX_FRAME_BYTES = 64;
    localparam int ADX_RAM_WORDS   = ADX_ENTRIES / 4;
    localparam int ADX_PTR_W       = $clog2(ADX_RAM_WORDS);
    localparam int ADX_IDX_W       = $clog2(ADX_FRAME_BYTES);
    localparam int ADX_LEN_W       = ADX_IDX_W + 1;
    localparam int ADX_CNT_W       = $clog2(ADX_SLOTS + 1);
    localparam int ADX_CTRL_W      = 14;

    localparam logic [ADX_CTRL_W-1:0] ADX_CTRL_MASK = 14'h3F0F;

    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_EN_LO   = 3'd1;
    localparam logic [2:0] RA_EN_HI   = 3'd2;
    localparam logic [2:0] RA_RAMCTL  = 3'd3;
    localparam logic [2:0] RA_RAMDATA = 3'd4;

    localparam int RC_INIT_BIT = 12;
    localparam int RC_SEQ_BIT  = 13;
    localparam int RC_RW_BIT   = 14;

    // Frame length in bytes: channels times bytes per sample.
    function automatic logic [ADX_LEN_W-1:0] adx_frame_len(input logic [ADX_CTRL_W-1:0] c);
        logic [ADX_LEN_W-1:0] ch;
        ch = ADX_LEN_W'(c[11:8]) + 1'b1;
        case (c[13:12])
            2'd0:    return ch;
            2'd1:    return ch << 1;
            default: return ch << 2;
        endcase
    endfunction
endpackage

// File: rtl/adx_cfg_regs.sv
module adx_cfg_regs
    import adx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [2:0]                    reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output logic [ADX_CTRL_W-1:0]         ctrl,
    output logic [ADX_ENTRIES*8-1:0]      map_flat,
    output logic [ADX_ENTRIES-1:0]        slot_en
);
    typedef struct packed {
        logic [ADX_RAM_WORDS-1:0][31:0] ram;
        logic [ADX_ENTRIES-1:0]         en;
        logic [ADX_CTRL_W-1:0]          ctrl;
        logic [ADX_PTR_W-1:0]           ptr;
        logic                           seq;
        logic                           rw;
    } cfg_s;

    cfg_s        s_d, s_q;
    logic [31:0] word_masked;

    always_comb begin
        s_d = s_q;
        for (int b = 0; b < 4; b++) begin
            word_masked[8*b +: 8] = s_q.en[int'(s_q.ptr)*4 + b] ? s_q.ram[s_q.ptr][8*b +: 8] : 8'h00;
        end
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL:   s_d.ctrl = reg_wdata[ADX_CTRL_W-1:0] & ADX_CTRL_MASK;
                RA_EN_LO:  s_d.en[31:0]  = reg_wdata;
                RA_EN_HI:  s_d.en[63:32] = reg_wdata;
                RA_RAMCTL: begin
                    s_d.seq = reg_wdata[RC_SEQ_BIT];
                    s_d.rw  = reg_wdata[RC_RW_BIT];
                    if (reg_wdata[RC_INIT_BIT]) s_d.ptr = reg_wdata[ADX_PTR_W-1:0];
                end
                RA_RAMDATA: begin
                    if (s_q.rw) begin
                        s_d.ram[s_q.ptr] = reg_wdata;
                        if (s_q.seq) s_d.ptr = s_q.ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (reg_rd && reg_addr == RA_RAMDATA && !s_q.rw && s_q.seq) begin
            s_d.ptr = s_q.ptr + 1'b1;
        end
        case (reg_addr)
            RA_CTRL:    reg_rdata = 32'(s_q.ctrl);
            RA_EN_LO:   reg_rdata = s_q.en[31:0];
            RA_EN_HI:   reg_rdata = s_q.en[63:32];
            RA_RAMCTL:  reg_rdata = 32'({s_q.rw, s_q.seq, 9'b0, s_q.ptr});
            RA_RAMDATA: reg_rdata = word_masked;
            default:    reg_rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl     = s_q.ctrl;
    assign map_flat = s_q.ram;
    assign slot_en  = s_q.en;

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_RAMDATA && s_q.rw && s_q.seq)
        |=> s_q.ptr == ADX_PTR_W'($past(s_q.ptr) + 1'b1));

    p_ignored_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_RAMDATA && !s_q.rw) |=> $stable(s_q.ram));
endmodule

// File: rtl/adx_frame_capture.sv
module adx_frame_capture
    import adx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [7:0]                    in_data,
    input  logic                          accept,
    input  logic [ADX_LEN_W-1:0]          frame_len,
    output logic                          frame_done,
    output logic [ADX_FRAME_BYTES*8-1:0]  frame_flat
);
    typedef struct packed {
        logic [ADX_FRAME_BYTES-1:0][7:0] bytes;
        logic [ADX_IDX_W-1:0]            cnt;
    } cap_s;

    cap_s s_d, s_q;
    logic take;

    always_comb begin
        s_d        = s_q;
        take       = accept && in_valid;
        frame_done = take && ({1'b0, s_q.cnt} == frame_len - 1'b1);
        if (take) begin
            s_d.bytes[s_q.cnt] = in_data;
            s_d.cnt = frame_done ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame_flat = s_q.bytes;

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> s_q.cnt == '0);
endmodule

// File: rtl/adx_lane_pack.sv
module adx_lane_pack
    import adx_pkg::*;
(
    input  logic [ADX_FRAME_BYTES*8-1:0] frame_flat,
    input  logic [ADX_SLOTS*8-1:0]       map_slice,
    input  logic [ADX_SLOTS-1:0]         en_slice,
    input  logic [ADX_LEN_W-1:0]         frame_len,
    output logic [ADX_SLOTS*8-1:0]       lane_data,
    output logic [ADX_CNT_W-1:0]         lane_cnt
);
    always_comb begin
        int                   pos;
        logic [ADX_IDX_W-1:0] idx;
        logic [7:0]           pick;
        lane_data = '0;
        pos       = 0;
        for (int j = 0; j < ADX_SLOTS; j++) begin
            idx  = map_slice[j*8 +: ADX_IDX_W];
            pick = ({1'b0, idx} < frame_len) ? frame_flat[int'(idx)*8 +: 8] : 8'h00;
            if (en_slice[j]) begin
                lane_data[pos*8 +: 8] = pick;
                pos = pos + 1;
            end
        end
        lane_cnt = ADX_CNT_W'(pos);
    end
endmodule

// File: rtl/adx_byte_demux.sv
module adx_byte_demux
    import adx_pkg::*;
(
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   reg_wr,
    input  logic                                   reg_rd,
    input  logic [2:0]                             reg_addr,
    input  logic [31:0]                            reg_wdata,
    output logic [31:0]                            reg_rdata,
    input  logic                                   in_valid,
    input  logic [7:0]                             in_data,
    output logic                                   in_ready,
    output logic [ADX_OUTS-1:0]                    out_valid,
    input  logic [ADX_OUTS-1:0]                    out_ready,
    output logic [ADX_OUTS*ADX_SLOTS*8-1:0]        out_data,
    output logic [ADX_OUTS*ADX_CNT_W-1:0]          out_count
);
    typedef struct packed {
        logic [ADX_OUTS-1:0] pend;
    } top_s;

    top_s                          s_d, s_q;
    logic [ADX_CTRL_W-1:0]         ctrl;
    logic [ADX_ENTRIES*8-1:0]      map_flat;
    logic [ADX_ENTRIES-1:0]        slot_en;
    logic [ADX_LEN_W-1:0]          frame_len;
    logic                          frame_done;
    logic [ADX_FRAME_BYTES*8-1:0]  frame_flat;

    adx_cfg_regs u_cfg (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .ctrl, .map_flat, .slot_en
    );

    assign frame_len = adx_frame_len(ctrl);

    adx_frame_capture u_cap (
        .clk, .rst_n, .in_valid, .in_data,
        .accept(in_ready), .frame_len, .frame_done, .frame_flat
    );

    for (genvar k = 0; k < ADX_OUTS; k++) begin : g_lane
        adx_lane_pack u_pack (
            .frame_flat,
            .map_slice(map_flat[k*ADX_SLOTS*8 +: ADX_SLOTS*8]),
            .en_slice (slot_en[k*ADX_SLOTS +: ADX_SLOTS]),
            .frame_len,
            .lane_data(out_data[k*ADX_SLOTS*8 +: ADX_SLOTS*8]),
            .lane_cnt (out_count[k*ADX_CNT_W +: ADX_CNT_W])
        );

        p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[k] && !out_ready[k]) |=> out_valid[k]);

        p_after_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_valid[k]) |-> $past(in_valid && in_ready));

        for (genvar p = 0; p < ADX_SLOTS; p++) begin : g_byte
            p_pack_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[k] && int'(out_count[k*ADX_CNT_W +: ADX_CNT_W]) <= p)
                |-> out_data[(k*ADX_SLOTS+p)*8 +: 8] == 8'h00);
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = s_q.pend & ~(out_valid & out_ready);
        if (frame_done) s_d.pend = ctrl[ADX_OUTS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready  = (s_q.pend == '0);
    assign out_valid = s_q.pend;
endmodule

// File: tb/test_adx_byte_demux.sv
module test_adx_byte_demux;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         reg_wr = 0, reg_rd = 0;
    logic [2:0]   reg_addr = 0;
    logic [31:0]  reg_wdata = 0;
    logic [31:0]  reg_rdata;
    logic         in_valid = 0;
    logic [7:0]   in_data = 0;
    logic         in_ready;
    logic [3:0]   out_valid;
    logic [3:0]   out_ready = 0;
    logic [511:0] out_data;
    logic [19:0]  out_count;

    always #10 clk = ~clk;

    adx_byte_demux i_adx_byte_demux (.*);

    int    total = 0, fails = 0, cyc = 0;
    string cur_tag = "R7";
    bit    rdy_all = 1;

    // reference model state
    logic [31:0] m_ram [16];
    logic [63:0] m_en;
    logic [13:0] m_ctrl;
    int          m_ptr;
    bit          m_seq, m_rw;
    logic [7:0]  m_buf [64];
    int          m_cnt;
    logic [3:0]  m_pend;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int mlen();
        int bps;
        bps = (m_ctrl[13:12] == 0) ? 1 : (m_ctrl[13:12] == 1) ? 2 : 4;
        return (int'(m_ctrl[11:8]) + 1) * bps;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] w;
        case (a)
            0: return 32'(m_ctrl);
            1: return m_en[31:0];
            2: return m_en[63:32];
            3: return (32'(m_rw) << 14) | (32'(m_seq) << 13) | 32'(m_ptr);
            4: begin
                w = 0;
                for (int b = 0; b < 4; b++)
                    if (m_en[m_ptr*4+b]) w[8*b +: 8] = m_ram[m_ptr][8*b +: 8];
                return w;
            end
            default: return 0;
        endcase
    endfunction

    task automatic exp_lane(input int k, output logic [127:0] d, output int c);
        logic [7:0] v;
        int idx;
        d = 0; c = 0;
        for (int j = 0; j < 16; j++) begin
            int e = 16*k + j;
            if (m_en[e]) begin
                v   = m_ram[e/4][8*(e%4) +: 8];
                idx = int'(v[5:0]);
                d[8*c +: 8] = (idx < mlen()) ? m_buf[idx] : 8'h00;
                c++;
            end
        end
    endtask

    // model update on each rising edge, datapath first (uses old config)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_ram[i] = 0;
            for (int i = 0; i < 64; i++) m_buf[i] = 0;
            m_en = 0; m_ctrl = 0; m_ptr = 0; m_seq = 0; m_rw = 0; m_cnt = 0; m_pend = 0;
        end else begin
            if (m_pend == 0) begin
                if (in_valid) begin
                    m_buf[m_cnt] = in_data;
                    if (m_cnt == mlen() - 1) begin
                        m_cnt = 0;
                        m_pend = m_ctrl[3:0];
                    end else m_cnt++;
                end
            end else begin
                m_pend = m_pend & ~out_ready;
            end
            if (reg_wr) begin
                case (reg_addr)
                    0: m_ctrl = reg_wdata[13:0] & 14'h3F0F;
                    1: m_en[31:0] = reg_wdata;
                    2: m_en[63:32] = reg_wdata;
                    3: begin
                        m_seq = reg_wdata[13]; m_rw = reg_wdata[14];
                        if (reg_wdata[12]) m_ptr = int'(reg_wdata[3:0]);
                    end
                    4: if (m_rw) begin
                        m_ram[m_ptr] = reg_wdata;
                        if (m_seq) m_ptr = (m_ptr + 1) % 16;
                    end
                    default: ;
                endcase
            end else if (reg_rd && reg_addr == 4 && !m_rw && m_seq) begin
                m_ptr = (m_ptr + 1) % 16;
            end
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [127:0] d;
            int c;
            chk(in_ready == (m_pend == 0), "R10", 128'(in_ready), 128'(m_pend == 0));
            chk(out_valid == m_pend, "R11", 128'(out_valid), 128'(m_pend));
            for (int k = 0; k < 4; k++) begin
                if (m_pend[k]) begin
                    exp_lane(k, d, c);
                    chk(out_data[128*k +: 128] == d && int'(out_count[5*k +: 5]) == c,
                        cur_tag, out_data[128*k +: 128], d);
                end
            end
            out_ready = rdy_all ? 4'hF : 4'($urandom);
        end else out_ready = 0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; fails++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, input string tag);
        logic [31:0] e;
        reg_rd = 1; reg_addr = 3'(a);
        #1;
        e = m_read(a);
        chk(reg_rdata == e, tag, 128'(reg_rdata), 128'(e));
        @(negedge clk);
        reg_rd = 0;
    endtask

    function automatic logic [7:0] mv(input int kind, input int e);
        case (kind)
            0:       return 8'((e*7 + 3) & 255);
            1:       return 8'(e | ((e & 1) << 7));
            default: return 8'((e*13) & 255);
        endcase
    endfunction

    task automatic load_map(input int kind);
        wr(3, 32'h7000);
        for (int w = 0; w < 16; w++)
            wr(4, {mv(kind, 4*w+3), mv(kind, 4*w+2), mv(kind, 4*w+1), mv(kind, 4*w)});
    endtask

    task automatic push(input int n, input int base);
        int i = 0;
        while (i < n) begin
            in_valid = 1;
            in_data  = 8'(base + 3*i);
            if (in_ready) i++;
            @(negedge clk);
        end
        in_valid = 0;
    endtask

    task automatic drain();
        while (m_pend != 0 || !in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] c, input string tag, input int base);
        cur_tag = tag;
        wr(0, c);
        push(mlen(), base);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1 && out_valid == 0, "R1", 128'({in_ready, out_valid}), 128'h10);
        for (int a = 0; a < 6; a++) rd(a, "R1");
        wr(5, 32'hFFFF_FFFF);
        rd(5, "R1");
        wr(0, 32'hFFFF_FFFF);
        rd(0, "R1");

        // R2: sequential load from word 0
        load_map(0);
        rd(3, "R2");
        // R4: everything disabled reads back as zero
        wr(3, 32'h3000);
        rd(4, "R4");
        wr(1, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'h3000);
        rd(4, "R2"); rd(4, "R2"); rd(4, "R2");
        rd(3, "R2");
        // R3: no sequential mode, pointer holds; write with read mode ignored
        wr(3, 32'h1005);
        rd(4, "R3"); rd(4, "R3");
        wr(4, 32'hDEAD_BEEF);
        rd(4, "R3");
        rd(3, "R3");
        // R5: enable bit layout
        wr(1, 32'h0000_0020);
        wr(2, 32'h0000_0100);
        rd(1, "R5"); rd(2, "R5");
        wr(3, 32'h1001); rd(4, "R5");
        wr(3, 32'h100A); rd(4, "R5");
        wr(1, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);

        // R8: out-of-frame indexes, 4 ch x 16 bit = 8 bytes
        rdy_all = 0;
        frame(32'h0000_130F, "R8", 1);
        frame(32'h0000_130F, "R8", 40);
        // R7: index map with upper bits set, 16 ch x 32 bit = 64 bytes
        load_map(1);
        frame(32'h0000_2F0F, "R7", 5);
        // R9: sparse enables and packing
        wr(1, 32'hF0F0_3C3C);
        wr(2, 32'hA5A5_0F0F);
        frame(32'h0000_2F0F, "R9", 9);
        load_map(2);
        frame(32'h0000_1703, "R9", 17);
        wr(1, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
        // R6: lengths 1 and 12
        frame(32'h0000_0005, "R6", 100);
        frame(32'h0000_320A, "R6", 7);

        // R12: no outputs enabled
        rdy_all = 1;
        cur_tag = "R12";
        wr(0, 32'h0000_1100);
        push(4, 60);
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && in_ready == 1, "R12", 128'({in_ready, out_valid}), 128'h10);

        // R10: outputs wait for the final byte
        cur_tag = "R10";
        wr(0, 32'h0000_110F);
        push(3, 80);
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R10", 128'(out_valid), 128'h0);
        rdy_all = 0;
        push(1, 89);
        chk(out_valid == 4'hF && in_ready == 0, "R10", 128'({in_ready, out_valid}), 128'h0F);
        drain();
        // R11: back-to-back frames under random stalls
        cur_tag = "R11";
        for (int f = 0; f < 6; f++) frame(32'h0000_110F, "R11", 20*f);
        drain();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule